// File: doc/BRIEF.md
# Configuration Bank Save/Restore Controller

This block is an I2C target that copies a bank of configuration registers into a non-volatile store, or reloads the bank from that store. The bus master sends a short command: the device address for a write, then one command byte. The command is held until the master ends the transaction with STOP, and only then does the copy start.

While the copy runs, `busy` is high and the target drives no ACK at all, not even for its own address. To every other master the bus therefore looks occupied until the copy has finished. Each operation lasts a fixed number of system clocks, one count for save and one for restore, and both counts are parameters. The store is a small synchronous memory model. It writes on the clock edge and reads without delay.

Normal software writes reach the register file through a valid/ready port. `hw_ready` is low for the whole copy. A beat that is offered during that time is not accepted, and the master of the port must hold it until `hw_ready` returns. Two read ports let the contents of the registers and of the store be observed. SDA is open-drain: `sda_oe` high pulls the line low.

Top module: `cfg_persist_ctrl`

## Requirements
- R1: A write of the device address (parameter `DEV_ADDR`, default 7'h5A) with R/W bit 0 is acknowledged, and so is the following command byte.
- R2: Bits [1:0] of the command byte select the operation: 2'b01 saves the registers into the store, 2'b10 restores the registers from the store. Bits [7:2] have no effect.
- R3: No operation starts and `busy` stays low until the master issues STOP. `busy` rises after that STOP.
- R4: While `busy` is high, the target never drives SDA low, even when its own address is sent.
- R5: After an operation completes, the target acknowledges its address again.
- R6: `busy` stays high for exactly `SAVE_CYCLES` clocks for a save and exactly `RESTORE_CYCLES` clocks for a restore.
- R7: A save leaves every store entry equal to the register at the same index.
- R8: A restore leaves every register equal to the store entry at the same index.
- R9: A wrong address, or the right address with R/W bit 1, is not acknowledged, and the STOP that follows starts nothing.
- R10: Command codes 2'b00 and 2'b11 are acknowledged but start no operation.
- R11: A repeated START before STOP discards a command that was already received.
- R12: `hw_ready` is low while `busy` is high. A beat offered during that time does not change any register. When `hw_ready` is high, a beat with `hw_valid` high writes `hw_wdata` to `hw_addr`.
- R13: After reset, `busy` is low, `sda_oe` is low, and every register and store entry is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe | output | 1 | High to pull SDA low (ACK) |
| busy | output | 1 | A save or restore is in progress |
| hw_valid | input | 1 | Register write beat offered |
| hw_ready | output | 1 | Register write beat can be accepted |
| hw_addr | input | $clog2(NREGS) | Register write index |
| hw_wdata | input | DW | Register write data |
| rd_addr | input | $clog2(NREGS) | Register readback index |
| rd_data | output | DW | Register readback data |
| st_addr | input | $clog2(NREGS) | Store readback index |
| st_data | output | DW | Store readback data |

## Verification
The bench builds the block with eight 8-bit registers, `SAVE_CYCLES` = 600 and `RESTORE_CYCLES` = 300, and an I2C bit period of 20 clocks. With these values, a complete address transaction fits inside either busy window. The bench can therefore probe the missing ACK and the locked write port while a copy is still running, and it can measure both busy durations to the exact cycle.

// File: rtl/cfg_persist_pkg.sv
package cfg_persist_pkg;
  localparam logic [1:0] OP_SAVE    = 2'b01;
  localparam logic [1:0] OP_RESTORE = 2'b10;

  typedef enum logic [2:0] {
    RX_IDLE, RX_ADDR, RX_AACK, RX_CMD, RX_CACK, RX_SKIP
  } rx_state_e;
endpackage

// File: rtl/cfg_cmd_rx.sv
module cfg_cmd_rx
  import cfg_persist_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h5A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       busy,
  output logic       ack_drv,
  output logic       go,
  output logic [1:0] go_op
);
  logic [1:0] scl_sync, sda_sync;
  logic       scl_q, sda_q;
  logic [7:0] shreg;
  logic [3:0] bitcnt;
  logic [1:0] armed;
  rx_state_e  st;

  wire scl_s    = scl_sync[1];
  wire sda_s    = sda_sync[1];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= RX_IDLE;
      shreg   <= '0;
      bitcnt  <= '0;
      armed   <= '0;
      ack_drv <= 1'b0;
      go      <= 1'b0;
      go_op   <= '0;
    end else begin
      go <= 1'b0;
      if (start_c) begin
        st      <= RX_ADDR;
        bitcnt  <= '0;
        armed   <= '0;
        ack_drv <= 1'b0;
      end else if (stop_c) begin
        go      <= ((armed == OP_SAVE) || (armed == OP_RESTORE)) && !busy;
        go_op   <= armed;
        armed   <= '0;
        st      <= RX_IDLE;
        ack_drv <= 1'b0;
      end else if (scl_rise && (st == RX_ADDR || st == RX_CMD)) begin
        shreg  <= {shreg[6:0], sda_s};
        bitcnt <= bitcnt + 4'd1;
      end else if (scl_fall) begin
        case (st)
          RX_ADDR: if (bitcnt == 4'd8) begin
            if (shreg == {DEV_ADDR, 1'b0} && !busy) begin
              ack_drv <= 1'b1;
              st      <= RX_AACK;
            end else begin
              st <= RX_SKIP;
            end
          end
          RX_AACK: begin
            ack_drv <= 1'b0;
            bitcnt  <= '0;
            st      <= RX_CMD;
          end
          RX_CMD: if (bitcnt == 4'd8) begin
            ack_drv <= 1'b1;
            armed   <= shreg[1:0];
            st      <= RX_CACK;
          end
          RX_CACK: begin
            ack_drv <= 1'b0;
            st      <= RX_SKIP;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_copy_engine.sv
module cfg_copy_engine
  import cfg_persist_pkg::*;
#(
  parameter int NREGS          = 8,
  parameter int SAVE_CYCLES    = 600,
  parameter int RESTORE_CYCLES = 300,
  localparam int AW   = $clog2(NREGS),
  localparam int MAXD = (SAVE_CYCLES > RESTORE_CYCLES) ? SAVE_CYCLES : RESTORE_CYCLES,
  localparam int CW   = $clog2(MAXD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [1:0]    go_op,
  output logic          busy,
  output logic [AW-1:0] idx,
  output logic          st_we,
  output logic          rf_we
);
  logic [CW-1:0] cnt;
  logic [1:0]    op;
  logic [CW-1:0] last;
  logic          copying;

  assign last    = (op == OP_SAVE) ? CW'(SAVE_CYCLES - 1) : CW'(RESTORE_CYCLES - 1);
  assign copying = busy && (cnt < CW'(NREGS));
  assign idx     = cnt[AW-1:0];
  assign st_we   = copying && (op == OP_SAVE);
  assign rf_we   = copying && (op == OP_RESTORE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      op   <= '0;
    end else if (!busy) begin
      if (go) begin
        busy <= 1'b1;
        cnt  <= '0;
        op   <= go_op;
      end
    end else begin
      cnt <= cnt + 1'b1;
      if (cnt == last) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/cfg_array.sv
module cfg_array #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          mem[i] <= '0;
      else if (we && waddr == AW'(i))      mem[i] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/cfg_persist_ctrl.sv
module cfg_persist_ctrl
  import cfg_persist_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h5A,
  parameter int NREGS            = 8,
  parameter int DW               = 8,
  parameter int SAVE_CYCLES      = 600,
  parameter int RESTORE_CYCLES   = 300,
  localparam int AW = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic          busy,
  input  logic          hw_valid,
  output logic          hw_ready,
  input  logic [AW-1:0] hw_addr,
  input  logic [DW-1:0] hw_wdata,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic [AW-1:0] st_addr,
  output logic [DW-1:0] st_data
);
  logic          op_go;
  logic [1:0]    op_code;
  logic [AW-1:0] cp_idx;
  logic          cp_st_we, cp_rf_we;
  logic [DW-1:0] rf_cp_data, st_cp_data;
  logic          rf_we;
  logic [AW-1:0] rf_waddr;
  logic [DW-1:0] rf_wdata;

  cfg_cmd_rx #(.DEV_ADDR(DEV_ADDR)) u_rx (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .busy(busy),
    .ack_drv(sda_oe), .go(op_go), .go_op(op_code)
  );

  cfg_copy_engine #(
    .NREGS(NREGS), .SAVE_CYCLES(SAVE_CYCLES), .RESTORE_CYCLES(RESTORE_CYCLES)
  ) u_eng (
    .clk(clk), .rst_n(rst_n), .go(op_go), .go_op(op_code), .busy(busy),
    .idx(cp_idx), .st_we(cp_st_we), .rf_we(cp_rf_we)
  );

  assign hw_ready = !busy;
  assign rf_we    = busy ? cp_rf_we : hw_valid;
  assign rf_waddr = busy ? cp_idx : hw_addr;
  assign rf_wdata = busy ? st_cp_data : hw_wdata;

  cfg_array #(.DEPTH(NREGS), .W(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .raddr_a(cp_idx), .rdata_a(rf_cp_data), .raddr_b(rd_addr), .rdata_b(rd_data)
  );

  cfg_array #(.DEPTH(NREGS), .W(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .we(cp_st_we), .waddr(cp_idx), .wdata(rf_cp_data),
    .raddr_a(cp_idx), .rdata_a(st_cp_data), .raddr_b(st_addr), .rdata_b(st_data)
  );
endmodule

// File: rtl/cfg_persist_chk.sv
module cfg_persist_chk
  import cfg_persist_pkg::*;
#(
  parameter int SAVE_CYCLES    = 600,
  parameter int RESTORE_CYCLES = 300
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       busy,
  input logic       go,
  input logic [1:0] go_op
);
  int unsigned run_len;
  int unsigned exp_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= 0;
      exp_len <= 0;
    end else if (go) begin
      run_len <= 0;
      exp_len <= (go_op == OP_SAVE) ? SAVE_CYCLES : RESTORE_CYCLES;
    end else if (busy) begin
      run_len <= run_len + 1;
    end
  end

  a_r4_no_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);
  a_r3_busy_after_go: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy);
  a_r3_rise_needs_go: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(go));
  a_r2_valid_code: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (go_op == OP_SAVE || go_op == OP_RESTORE));
  a_r6_duration: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_len == exp_len);
  a_r4_no_go_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !go);
endmodule

bind cfg_persist_ctrl cfg_persist_chk #(
  .SAVE_CYCLES(SAVE_CYCLES), .RESTORE_CYCLES(RESTORE_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .busy(busy),
  .go(op_go), .go_op(op_code)
);

// File: tb/sim_cfg_persist_ctrl.sv
module sim_cfg_persist_ctrl;
  localparam logic [6:0] DEV = 7'h5A;
  localparam int NREGS = 8;
  localparam int DW    = 8;
  localparam int SAVE  = 600;
  localparam int REST  = 300;
  localparam int AW    = $clog2(NREGS);
  localparam int Q     = 5;

  logic clk = 0, rst_n = 0;
  logic scl_m = 1, sda_m = 1;
  logic sda_oe, busy, hw_valid = 0, hw_ready;
  logic [AW-1:0] hw_addr = '0, rd_addr = '0, st_addr = '0;
  logic [DW-1:0] hw_wdata = '0, rd_data, st_data;
  logic sda_line;
  assign sda_line = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  cfg_persist_ctrl #(.DEV_ADDR(DEV), .NREGS(NREGS), .DW(DW),
    .SAVE_CYCLES(SAVE), .RESTORE_CYCLES(REST)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .busy(busy), .hw_valid(hw_valid), .hw_ready(hw_ready), .hw_addr(hw_addr),
    .hw_wdata(hw_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
    .st_addr(st_addr), .st_data(st_data));

  int n_chk = 0, n_err = 0;
  logic [DW-1:0] mreg [NREGS];
  logic [DW-1:0] mst  [NREGS];
  int run_len = 0, last_len = 0;

  always @(negedge clk) begin
    if (busy) run_len <= run_len + 1;
    else if (run_len != 0) begin last_len <= run_len; run_len <= 0; end
  end

  function automatic int exp_dur(logic [1:0] code);
    return (code == 2'b01) ? SAVE : (code == 2'b10) ? REST : 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wq(int n); repeat (n) @(negedge clk); endtask

  task automatic i2c_start;
    sda_m = 1; wq(Q); scl_m = 1; wq(Q); sda_m = 0; wq(Q); scl_m = 0; wq(Q);
  endtask
  task automatic i2c_stop;
    sda_m = 0; wq(Q); scl_m = 1; wq(Q); sda_m = 1; wq(Q);
  endtask
  task automatic i2c_byte(input logic [7:0] b, output int ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q); scl_m = 1; wq(2*Q); scl_m = 0; wq(Q);
    end
    sda_m = 1; wq(Q); scl_m = 1; wq(Q); ack = (sda_line == 1'b0) ? 1 : 0;
    wq(Q); scl_m = 0; wq(Q);
  endtask

  task automatic hwrite(input int a, input logic [DW-1:0] d);
    hw_addr = AW'(a); hw_wdata = d; hw_valid = 1;
    wq(1);
    if (hw_ready === 1'b1 || busy == 1'b0) mreg[a] = d;
    hw_valid = 0;
  endtask

  task automatic wait_idle;
    for (int i = 0; i < 5000 && busy; i++) wq(1);
    wq(2);
  endtask

  task automatic cmp_all(string req);
    for (int i = 0; i < NREGS; i++) begin
      rd_addr = AW'(i); st_addr = AW'(i); #1;
      chk(req, int'(rd_data), int'(mreg[i]));
      chk(req, int'(st_data), int'(mst[i]));
    end
  endtask

  task automatic send_cmd(input logic [7:0] a, input logic [7:0] c,
                          output int aa, output int ca);
    i2c_start; i2c_byte(a, aa);
    if (aa != 0) i2c_byte(c, ca); else ca = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int aa, ca;
    logic [7:0] code;
    void'($urandom(32'd4711));
    for (int i = 0; i < NREGS; i++) begin mreg[i] = '0; mst[i] = '0; end
    wq(5); rst_n = 1; wq(5);
    // R13 reset state
    chk("R13 busy", int'(busy), 0);
    chk("R13 sda_oe", int'(sda_oe), 0);
    cmp_all("R13 contents");

    // R12 host writes accepted when idle
    chk("R12 ready idle", int'(hw_ready), 1);
    for (int i = 0; i < NREGS; i++) hwrite(i, 8'($urandom));
    cmp_all("R12 write idle");

    // R1 R2 R3 save with random upper bits
    code = {6'($urandom), 2'b01};
    send_cmd({DEV, 1'b0}, code, aa, ca);
    chk("R1 addr ack", aa, 1);
    chk("R1 cmd ack", ca, 1);
    wq(20);
    chk("R3 no busy before stop", int'(busy), 0);
    i2c_stop; wq(10);
    chk("R3 busy after stop", int'(busy), 1);
    // R4 own address refused during busy
    i2c_start; i2c_byte({DEV, 1'b0}, aa); i2c_stop;
    chk("R4 no ack busy", aa, 0);
    // R12 write locked during busy
    chk("R12 ready busy", int'(hw_ready), 0);
    begin
      logic [DW-1:0] keep;
      keep = mreg[3];
      hwrite(3, ~keep);
      mreg[3] = keep;
    end
    wait_idle;
    for (int i = 0; i < NREGS; i++) mst[i] = mreg[i];
    chk("R6 save length", last_len, exp_dur(2'b01));
    cmp_all("R7 R12 save copy");

    // R5 acks again
    i2c_start; i2c_byte({DEV, 1'b0}, aa); i2c_stop; wq(10);
    chk("R5 ack after done", aa, 1);
    chk("R5 no busy", int'(busy), 0);

    // change registers, then R8 restore
    for (int i = 0; i < NREGS; i++) hwrite(i, 8'($urandom));
    code = {6'($urandom), 2'b10};
    send_cmd({DEV, 1'b0}, code, aa, ca);
    chk("R2 restore ack", ca, 1);
    i2c_stop; wq(10);
    chk("R2 restore busy", int'(busy), 1);
    wait_idle;
    for (int i = 0; i < NREGS; i++) mreg[i] = mst[i];
    chk("R6 restore length", last_len, exp_dur(2'b10));
    cmp_all("R8 restore copy");

    for (int i = 0; i < NREGS; i++) hwrite(i, 8'($urandom));
    // R9 wrong address and read bit
    send_cmd({DEV ^ 7'h01, 1'b0}, 8'h01, aa, ca); i2c_stop; wq(10);
    chk("R9 wrong addr ack", aa, 0);
    chk("R9 wrong addr busy", int'(busy), 0);
    send_cmd({DEV, 1'b1}, 8'h01, aa, ca); i2c_stop; wq(10);
    chk("R9 read bit ack", aa, 0);
    chk("R9 read bit busy", int'(busy), 0);
    // R10 null codes
    for (int k = 0; k < 2; k++) begin
      code = {6'($urandom), (k == 0) ? 2'b00 : 2'b11};
      send_cmd({DEV, 1'b0}, code, aa, ca);
      chk("R10 code ack", ca, 1);
      i2c_stop; wq(10);
      chk("R10 no busy", int'(busy), 0);
    end
    // R11 repeated start discards armed save
    send_cmd({DEV, 1'b0}, 8'h01, aa, ca);
    chk("R11 first ack", ca, 1);
    i2c_start; i2c_byte({DEV ^ 7'h10, 1'b0}, aa); i2c_stop; wq(10);
    chk("R11 no busy", int'(busy), 0);
    cmp_all("R9 R10 R11 contents unchanged");

    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule